// File: doc/BRIEF.md
# RAM Address and Data Scrambler

This block sits between a processor's memory bus and a word-addressed RAM. It hides where program data lives in the RAM and what the stored words look like. Two keys set the transform. The address key permutes the physical word index. The data key, together with the logical word address, masks every word written. On the way back the block removes the mask, so software sees ordinary read-after-write memory behaviour. The RAM itself is outside the block.

Boot code loads both keys through a small configuration port. The keys are fresh random values on each power-up, and the transform is cheap rather than cryptographically strong. A lock input marks the start of the application phase. Once the lock has been seen, the keys are frozen until the next reset, so a running application cannot change or reset the mapping.

Top module: `ram_scrambler`

## Requirements
- R1: Both keys are zero out of reset. With zero keys, `ram_addr_o` equals `cpu_addr_i` and `ram_wdata_o` equals `cpu_wdata_i` XOR the zero-extended logical word address.
- R2: When `cfg_we_i` is high with `cfg_sel_i`=0, the address key takes the low ADDR_W bits of `cfg_wdata_i` at the next clock edge. From then on, `ram_addr_o` = `cpu_addr_i` XOR the address key, in the same cycle.
- R3: When `cfg_we_i` is high with `cfg_sel_i`=1, the data key takes `cfg_wdata_i` at the next clock edge. From then on, `ram_wdata_o` = `cpu_wdata_i` XOR the data key XOR the zero-extended `cpu_addr_i`, in the same cycle.
- R4: The RAM has one cycle of read latency. In the cycle after a read request (`cpu_req_i`=1, `cpu_we_i`=0), `cpu_rdata_o` equals `ram_rdata_i` XOR the data key XOR the request's zero-extended address. A full-word write followed by a read of the same address therefore returns the written word.
- R5: `ram_en_o`, `ram_we_o` and `ram_wstrb_o` equal `cpu_req_i`, `cpu_we_i` and `cpu_wstrb_i` in the same cycle. `cpu_wstrb_i` bit i enables byte i, which is data bits 8i+7 down to 8i.
- R6: Once `lock_i` has been high at a clock edge, later configuration writes are ignored until reset. This holds even after `lock_i` falls. A configuration write in the same cycle as the first `lock_i` is also ignored.
- R7: Reset clears the lock and both keys. After reset, configuration writes take effect again.
- R8: For any address key, the mapping from logical to physical word address is a bijection over all 2^ADDR_W words.
- R9: A partial write through byte strobes changes only the enabled bytes. A later read returns the merged word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_i | input | 1 | Application-phase start; freezes the keys |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | Key select: 0 address key, 1 data key |
| cfg_wdata_i | input | DATA_W | Key value |
| cpu_req_i | input | 1 | Bus access request |
| cpu_we_i | input | 1 | Write (1) or read (0) |
| cpu_addr_i | input | ADDR_W | Logical word address |
| cpu_wstrb_i | input | DATA_W/8 | Byte write enables |
| cpu_wdata_i | input | DATA_W | Write data |
| cpu_rdata_o | output | DATA_W | Unscrambled read data |
| ram_en_o | output | 1 | RAM enable |
| ram_we_o | output | 1 | RAM write enable |
| ram_addr_o | output | ADDR_W | Physical word address |
| ram_wstrb_o | output | DATA_W/8 | RAM byte enables |
| ram_wdata_o | output | DATA_W | Scrambled write data |
| ram_rdata_i | input | DATA_W | Raw RAM read data, one cycle after the request |

## Verification
The address map is checked in three ways: with zero keys, with a mixed-bit key, and with a sweep of every logical address. The sweep proves that no two addresses collide. Write data is checked with all-zeros, all-ones and alternating patterns at several addresses. These patterns separate the data-key term from the address term, and round trips through a RAM model show that reads undo both. A merge through alternate byte strobes tells real per-byte masking apart from whole-word handling. Key writes are tried in the lock cycle, after lock_i falls, and after a reset, which separates a sticky lock from a level-sensitive one.

// File: rtl/scr_pkg.sv
package scr_pkg;
   typedef enum logic {
      CFG_ADDR_KEY = 1'b0,
      CFG_DATA_KEY = 1'b1
   } cfg_sel_e;
endpackage

// File: rtl/scr_cfg_regs.sv
module scr_cfg_regs #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lock_i,
   input  logic              we_i,
   input  logic              sel_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [ADDR_W-1:0] akey_o,
   output logic [DATA_W-1:0] dkey_o
);
   logic              locked_q;
   logic [ADDR_W-1:0] akey_q;
   logic [DATA_W-1:0] dkey_q;
   logic              wr_ok;

   assign wr_ok = we_i && !locked_q && !lock_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked_q <= 1'b0;
         akey_q   <= '0;
         dkey_q   <= '0;
      end else begin
         if (lock_i) locked_q <= 1'b1;
         if (wr_ok && sel_i == scr_pkg::CFG_ADDR_KEY) akey_q <= wdata_i[ADDR_W-1:0];
         if (wr_ok && sel_i == scr_pkg::CFG_DATA_KEY) dkey_q <= wdata_i;
      end
   end

   assign akey_o = akey_q;
   assign dkey_o = dkey_q;

   // R6: the lock never clears on its own
   assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      locked_q |=> locked_q);
   // R6: keys hold once lock is seen
   assert_keys_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_i || locked_q) |=> ($stable(akey_q) && $stable(dkey_q)));
   // R3: an unlocked data-key write lands
   assert_dkey_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && !lock_i && !locked_q && sel_i == scr_pkg::CFG_DATA_KEY) |=> dkey_o == $past(wdata_i));
endmodule

// File: rtl/scr_addr_map.sv
module scr_addr_map #(
   parameter int ADDR_W = 10
) (
   input  logic [ADDR_W-1:0] laddr_i,
   input  logic [ADDR_W-1:0] akey_i,
   output logic [ADDR_W-1:0] paddr_o
);
   // XOR with a fixed key is its own inverse, hence a bijection
   assign paddr_o = laddr_i ^ akey_i;
endmodule

// File: rtl/scr_data_xform.sv
module scr_data_xform #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] data_i,
   input  logic [DATA_W-1:0] key_i,
   input  logic [ADDR_W-1:0] laddr_i,
   output logic [DATA_W-1:0] data_o
);
   logic [DATA_W-1:0] tweak;

   generate
      if (DATA_W > ADDR_W) begin : g_ext
         assign tweak = {{(DATA_W-ADDR_W){1'b0}}, laddr_i};
      end else begin : g_same
         assign tweak = laddr_i;
      end
   endgenerate

   assign data_o = data_i ^ key_i ^ tweak;
endmodule

// File: rtl/ram_scrambler.sv
module ram_scrambler #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 32,
   localparam int STRB_W = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lock_i,
   input  logic              cfg_we_i,
   input  logic              cfg_sel_i,
   input  logic [DATA_W-1:0] cfg_wdata_i,
   input  logic              cpu_req_i,
   input  logic              cpu_we_i,
   input  logic [ADDR_W-1:0] cpu_addr_i,
   input  logic [STRB_W-1:0] cpu_wstrb_i,
   input  logic [DATA_W-1:0] cpu_wdata_i,
   output logic [DATA_W-1:0] cpu_rdata_o,
   output logic              ram_en_o,
   output logic              ram_we_o,
   output logic [ADDR_W-1:0] ram_addr_o,
   output logic [STRB_W-1:0] ram_wstrb_o,
   output logic [DATA_W-1:0] ram_wdata_o,
   input  logic [DATA_W-1:0] ram_rdata_i
);
   initial begin
      assert (DATA_W % 8 == 0 && ADDR_W >= 1 && ADDR_W <= DATA_W)
         else $error("ram_scrambler: bad ADDR_W/DATA_W");
   end

   logic [ADDR_W-1:0] akey;
   logic [DATA_W-1:0] dkey;
   logic [ADDR_W-1:0] rd_addr_q;

   scr_cfg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .lock_i(lock_i), .we_i(cfg_we_i),
      .sel_i(cfg_sel_i), .wdata_i(cfg_wdata_i), .akey_o(akey), .dkey_o(dkey)
   );

   scr_addr_map #(.ADDR_W(ADDR_W)) u_amap (
      .laddr_i(cpu_addr_i), .akey_i(akey), .paddr_o(ram_addr_o)
   );

   scr_data_xform #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
      .data_i(cpu_wdata_i), .key_i(dkey), .laddr_i(cpu_addr_i), .data_o(ram_wdata_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    rd_addr_q <= '0;
      else if (cpu_req_i && !cpu_we_i) rd_addr_q <= cpu_addr_i;
   end

   scr_data_xform #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
      .data_i(ram_rdata_i), .key_i(dkey), .laddr_i(rd_addr_q), .data_o(cpu_rdata_o)
   );

   assign ram_en_o    = cpu_req_i;
   assign ram_we_o    = cpu_we_i;
   assign ram_wstrb_o = cpu_wstrb_i;

   // R2/R8: while locked, the address offset is one fixed key
   assert_addr_key_const_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_i && $past(lock_i)) |-> ((ram_addr_o ^ cpu_addr_i) == $past(ram_addr_o ^ cpu_addr_i)));
endmodule

// File: tb/sim_ram_scrambler.sv
module sim_ram_scrambler;
   localparam int AW = 10;
   localparam int DW = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lock_i = 1'b0, cfg_we_i = 1'b0, cfg_sel_i = 1'b0;
   logic [DW-1:0] cfg_wdata_i = '0;
   logic cpu_req_i = 1'b0, cpu_we_i = 1'b0;
   logic [AW-1:0] cpu_addr_i = '0;
   logic [3:0] cpu_wstrb_i = '0;
   logic [DW-1:0] cpu_wdata_i = '0;
   logic [DW-1:0] cpu_rdata_o, ram_wdata_o, ram_rdata_i;
   logic ram_en_o, ram_we_o;
   logic [AW-1:0] ram_addr_o;
   logic [3:0] ram_wstrb_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic [DW-1:0] mem [1024];
   logic [AW-1:0] akey_m = '0;
   logic [DW-1:0] dkey_m = '0;

   always #2 clk = ~clk;

   ram_scrambler #(.ADDR_W(AW), .DATA_W(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .lock_i(lock_i), .cfg_we_i(cfg_we_i),
      .cfg_sel_i(cfg_sel_i), .cfg_wdata_i(cfg_wdata_i), .cpu_req_i(cpu_req_i),
      .cpu_we_i(cpu_we_i), .cpu_addr_i(cpu_addr_i), .cpu_wstrb_i(cpu_wstrb_i),
      .cpu_wdata_i(cpu_wdata_i), .cpu_rdata_o(cpu_rdata_o), .ram_en_o(ram_en_o),
      .ram_we_o(ram_we_o), .ram_addr_o(ram_addr_o), .ram_wstrb_o(ram_wstrb_o),
      .ram_wdata_o(ram_wdata_o), .ram_rdata_i(ram_rdata_i)
   );

   always @(posedge clk) begin
      if (ram_en_o) begin
         if (ram_we_o) begin
            for (int b = 0; b < 4; b++)
               if (ram_wstrb_o[b]) mem[ram_addr_o][8*b +: 8] <= ram_wdata_o[8*b +: 8];
         end else begin
            ram_rdata_i <= mem[ram_addr_o];
         end
      end
   end

   function automatic logic [DW-1:0] scr(input logic [DW-1:0] d, input logic [AW-1:0] a);
      return d ^ dkey_m ^ {{(DW-AW){1'b0}}, a};
   endfunction

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cfg_write(input logic sel, input logic [DW-1:0] v, input bit expect_take);
      @(negedge clk);
      cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = v;
      @(negedge clk);
      cfg_we_i = 1'b0;
      if (expect_take) begin
         if (sel) dkey_m = v; else akey_m = v[AW-1:0];
      end
   endtask

   task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [3:0] s);
      @(negedge clk);
      cpu_req_i = 1'b1; cpu_we_i = 1'b1; cpu_addr_i = a; cpu_wdata_i = d; cpu_wstrb_i = s;
      #1;
      chk("R5 strobes", {28'd0, ram_wstrb_o}, {28'd0, s});
      chk("R5 en/we", {30'd0, ram_en_o, ram_we_o}, 32'd3);
      @(negedge clk);
      cpu_req_i = 1'b0; cpu_we_i = 1'b0; cpu_wstrb_i = '0;
   endtask

   task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
      @(negedge clk);
      cpu_req_i = 1'b1; cpu_we_i = 1'b0; cpu_addr_i = a;
      @(negedge clk);
      cpu_req_i = 1'b0;
      #1 d = cpu_rdata_o;
   endtask

   task automatic t_reset_state();
      @(negedge clk);
      cpu_addr_i = 10'h2B7; cpu_wdata_i = 32'hDEAD_BEEF;
      #1;
      chk("R1 addr identity", {22'd0, ram_addr_o}, {22'd0, 10'h2B7});
      chk("R1 data addr-only", ram_wdata_o, 32'hDEAD_BEEF ^ 32'h2B7);
   endtask

   task automatic t_addr_map();
      cfg_write(1'b0, 32'hFFFF_F2C6, 1'b1);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         cpu_addr_i = (i == 0) ? 10'h000 : (i == 1) ? 10'h3FF : 10'h155;
         #1;
         chk("R2 addr map", {22'd0, ram_addr_o}, {22'd0, cpu_addr_i ^ 10'h2C6});
      end
   endtask

   task automatic t_data_scramble();
      logic [DW-1:0] pats [3];
      pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'h5A5A_A5A5;
      cfg_write(1'b1, 32'h1357_9BDF, 1'b1);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         cpu_addr_i = 10'h0F0 + 10'(i); cpu_wdata_i = pats[i];
         #1;
         chk("R3 data scramble", ram_wdata_o, pats[i] ^ 32'h1357_9BDF ^ {22'd0, cpu_addr_i});
      end
   endtask

   task automatic t_roundtrip();
      logic [DW-1:0] r;
      logic [AW-1:0] as [4];
      as[0] = 10'h000; as[1] = 10'h3FF; as[2] = 10'h123; as[3] = 10'h2C6;
      for (int i = 0; i < 4; i++) bus_write(as[i], 32'hC0DE_0000 + 32'(i * 32'h1111), 4'hF);
      chk("R3 stored word", mem[as[2] ^ akey_m], scr(32'hC0DE_0000 + 32'h2222, as[2]));
      for (int i = 0; i < 4; i++) begin
         bus_read(as[i], r);
         chk("R4 round trip", r, 32'hC0DE_0000 + 32'(i * 32'h1111));
      end
   endtask

   task automatic t_strobes();
      logic [DW-1:0] r;
      bus_write(10'h0AA, 32'h1122_3344, 4'hF);
      bus_write(10'h0AA, 32'hAABB_CCDD, 4'b0101);
      bus_read(10'h0AA, r);
      chk("R9 byte merge", r, 32'h11BB_33DD);
   endtask

   task automatic t_bijection();
      bit seen [1024];
      int dup = 0;
      for (int a = 0; a < 1024; a++) begin
         @(negedge clk);
         cpu_addr_i = 10'(a);
         #1;
         if (seen[ram_addr_o]) dup++;
         seen[ram_addr_o] = 1'b1;
      end
      chk("R8 bijection collisions", 32'(dup), 32'd0);
   endtask

   task automatic t_lock();
      logic [DW-1:0] r;
      @(negedge clk);
      lock_i = 1'b1; cfg_we_i = 1'b1; cfg_sel_i = 1'b0; cfg_wdata_i = 32'h0000_0011;
      @(negedge clk);
      cfg_we_i = 1'b0; lock_i = 1'b0;
      cfg_write(1'b1, 32'hFFFF_0000, 1'b0);
      cfg_write(1'b0, 32'h0000_0077, 1'b0);
      @(negedge clk);
      cpu_addr_i = 10'h001; cpu_wdata_i = 32'h0;
      #1;
      chk("R6 addr key frozen", {22'd0, ram_addr_o}, {22'd0, 10'h001 ^ akey_m});
      chk("R6 data key frozen", ram_wdata_o, scr(32'h0, 10'h001));
      bus_read(10'h123, r);
      chk("R6 data still readable", r, 32'hC0DE_2222);
      @(negedge clk);
      rst_n = 1'b0;
      akey_m = '0; dkey_m = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      cpu_addr_i = 10'h155; cpu_wdata_i = 32'h0;
      #1;
      chk("R7 keys cleared addr", {22'd0, ram_addr_o}, {22'd0, 10'h155});
      chk("R7 keys cleared data", ram_wdata_o, 32'h155);
      cfg_write(1'b0, 32'h0000_0300, 1'b1);
      @(negedge clk);
      #1;
      chk("R7 lock cleared", {22'd0, ram_addr_o}, {22'd0, 10'h155 ^ 10'h300});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset_state();
      t_addr_map();
      t_data_scramble();
      t_roundtrip();
      t_strobes();
      t_bijection();
      t_lock();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #800000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule